// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a block-oriented memory. It holds 256 lines of four 32-bit words. Each 32-bit byte address maps to exactly one line, and the line's stored tag decides whether the access hits. Stores stay in the cache and mark the line dirty. Memory sees a dirty line only when a later miss on the same index evicts it. A store that misses first brings the block in and then merges the word into it.

The processor holds `cpu_req` and its address, write flag and data steady until `cpu_ready` pulses for one cycle. A hit completes one cycle after the request is taken, with no memory traffic. A miss makes one block transfer when the victim is clean or invalid, and two when it is dirty: the victim is written out first, then the new block is read in. The memory side raises `mem_req` with `mem_we`, a block-aligned `mem_addr` and, for writes, the whole line on `mem_wdata`. The memory completes the transfer with a single-cycle `mem_ack`, and for reads it presents the block on `mem_rdata` in that same cycle.

Top module: `dmc_cache`

## Requirements
- R1: Address bits 11:4 select the line and bits 3:2 select the word within it (word n sits at bits 32n+31:32n of a block). Bits 1:0 have no effect, and every memory transfer uses an address whose low four bits are zero.
- R2: An access hits only when the selected line is valid and its stored tag equals address bits 31:12. Any other access is a miss.
- R3: A load hit returns the cached word with `cpu_ready` high one cycle after the request is taken, and makes no memory transfer.
- R4: A store hit changes only the addressed cached word and marks the line dirty, with no memory transfer. Memory keeps its old value until eviction.
- R5: A store miss reads the block from memory, merges the store word into it and leaves the line dirty. A later eviction writes out the merged block.
- R6: A miss whose victim line is valid and dirty first writes the whole victim line to the address built from the stored tag, the current index and zero offset bits. The refill read follows.
- R7: A miss whose victim is invalid or clean makes exactly one memory transfer, a read of the requested block.
- R8: After a load-miss refill the line is clean, so evicting it later causes no write-back.
- R9: `cpu_ready` stays low while a memory transfer is requested, and it pulses for exactly one cycle per request.
- R10: Reset clears every valid and dirty bit. After reset, `cpu_ready` and `mem_req` are low and the first access to any line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load word, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 128 | Line written on a write-back |
| mem_rdata | input | 128 | Block returned on a read |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The hardest situation to reach from the ports is a dirty victim whose contents come from a store miss. Reaching it takes a store to a line that was not resident, followed by a conflicting access to the same index with a different tag. Directed accesses build this sequence explicitly. Random traffic then confines addresses to four tags and four indexes, including index 255, so conflict evictions of both clean and dirty lines happen often. The memory model answers after random delays, and every transfer's kind, address and write-back data is compared against a reference of the latest value of every word.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINES      = 256;
    localparam int WORDS      = 4;
    localparam int BOFF_W     = $clog2(WORD_W / 8);
    localparam int WOFF_W     = $clog2(WORDS);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - WOFF_W - BOFF_W;
    localparam int LINE_W     = WORD_W * WORDS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL
    } dmc_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WOFF_W-1:0] word;
        logic [BOFF_W-1:0] boff;
    } dmc_addr_t;

    function automatic logic [ADDR_W-1:0] block_addr(
        input logic [TAG_W-1:0] tag,
        input logic [IDX_W-1:0] idx
    );
        return {tag, idx, {(WOFF_W + BOFF_W){1'b0}}};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             set_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] drt_q;
    logic [TAG_W-1:0] tags_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
        end else if (fill_we) begin
            vld_q[idx] <= 1'b1;
            drt_q[idx] <= 1'b0;
        end else if (set_dirty) begin
            drt_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) tags_q[idx] <= fill_tag;
    end

    assign line_valid = vld_q[idx];
    assign line_dirty = drt_q[idx];
    assign line_tag   = tags_q[idx];

    AST_DIRTY_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        set_dirty |-> line_valid); // R4
    AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> (line_valid && !line_dirty && line_tag == $past(fill_tag))); // R8
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_we,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              word_we,
    input  logic [WOFF_W-1:0] word_sel,
    input  logic [WORD_W-1:0] word_wdata,
    output logic [LINE_W-1:0] rd_line
);
    for (genvar lane = 0; lane < WORDS; lane++) begin : g_lane
        logic [WORD_W-1:0] arr_q [LINES];

        always_ff @(posedge clk) begin
            if (fill_we)
                arr_q[idx] <= fill_line[lane*WORD_W +: WORD_W];
            else if (word_we && word_sel == WOFF_W'(lane))
                arr_q[idx] <= word_wdata;
        end

        assign rd_line[lane*WORD_W +: WORD_W] = arr_q[idx];
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic              mem_ack,
    output logic [TAG_W-1:0]  req_tag,
    output logic [IDX_W-1:0]  req_idx,
    output logic [WOFF_W-1:0] req_word,
    output logic [WORD_W-1:0] req_wdata,
    output logic              cpu_ready,
    output logic              word_we,
    output logic              fill_we,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    dmc_state_e state_q, state_d;
    dmc_addr_t  in_addr;
    logic       we_q;
    logic       hit;
    logic       unused_boff;

    assign in_addr     = dmc_addr_t'(cpu_addr);
    assign unused_boff = ^in_addr.boff;
    assign hit         = line_valid && (line_tag == req_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            we_q      <= 1'b0;
            req_tag   <= '0;
            req_idx   <= '0;
            req_word  <= '0;
            req_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                we_q      <= cpu_we;
                req_tag   <= in_addr.tag;
                req_idx   <= in_addr.idx;
                req_word  <= in_addr.word;
                req_wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        word_we   = 1'b0;
        fill_we   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    word_we   = we_q;
                    state_d   = ST_IDLE;
                end else if (line_valid && line_dirty) begin
                    state_d = ST_WRITEBACK;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = block_addr(line_tag, req_idx);
                if (mem_ack) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = block_addr(req_tag, req_idx);
                if (mem_ack) begin
                    fill_we = 1'b1;
                    state_d = ST_COMPARE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_READY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready); // R9
    AST_NO_READY_DURING_XFER: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready); // R9
    AST_WB_ONLY_DIRTY_VICTIM: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITEBACK && $past(state_q) == ST_COMPARE)
            |-> $past(line_valid && line_dirty)); // R6
    AST_XFER_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[WOFF_W+BOFF_W-1:0] == '0)); // R1
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFF_W-1:0] req_word;
    logic [WORD_W-1:0] req_wdata;
    logic              word_we;
    logic              fill_we;
    logic              line_valid;
    logic              line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [LINE_W-1:0] rd_line;

    dmc_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .mem_ack    (mem_ack),
        .req_tag    (req_tag),
        .req_idx    (req_idx),
        .req_word   (req_word),
        .req_wdata  (req_wdata),
        .cpu_ready  (cpu_ready),
        .word_we    (word_we),
        .fill_we    (fill_we),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    dmc_tag_store i_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (req_idx),
        .fill_we    (fill_we),
        .fill_tag   (req_tag),
        .set_dirty  (word_we),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    dmc_data_store i_data (
        .clk        (clk),
        .idx        (req_idx),
        .fill_we    (fill_we),
        .fill_line  (mem_rdata),
        .word_we    (word_we),
        .word_sel   (req_word),
        .word_wdata (req_wdata),
        .rd_line    (rd_line)
    );

    assign cpu_rdata = rd_line[req_word*WORD_W +: WORD_W];
    assign mem_wdata = rd_line;
endmodule

// File: tb/test_dmc_cache.sv
module test_dmc_cache;
    logic         clk = 1'b0;
    logic         rst;
    logic         cpu_req;
    logic         cpu_we;
    logic [31:0]  cpu_addr;
    logic [31:0]  cpu_wdata;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata;
    logic         mem_ack;

    always #10 clk = ~clk;

    dmc_cache i_dmc_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    bit [31:0]  refw [bit [29:0]];
    bit [127:0] bmem [bit [27:0]];
    bit         m_valid [256];
    bit         m_dirty [256];
    bit [19:0]  m_tag   [256];

    int         xfer_n;
    bit         xfer_we   [8];
    bit [31:0]  xfer_addr [8];
    bit [127:0] xfer_data [8];

    function automatic bit [31:0] init_word(bit [29:0] wa);
        return {wa, 2'b00} ^ 32'hC3A5_0F1E ^ (32'(wa) << 7);
    endfunction

    function automatic bit [31:0] ref_rd(bit [29:0] wa);
        if (refw.exists(wa)) return refw[wa];
        return init_word(wa);
    endfunction

    function automatic bit [127:0] ref_line(bit [27:0] bn);
        bit [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = ref_rd({bn, 2'(w)});
        return l;
    endfunction

    function automatic bit [127:0] back_line(bit [27:0] bn);
        bit [127:0] l;
        if (bmem.exists(bn)) return bmem[bn];
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = init_word({bn, 2'(w)});
        return l;
    endfunction

    task automatic check(bit ok, string req, string what, bit [127:0] act, bit [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: random latency, one-cycle ack
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && !rst) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                if (xfer_n < 8) begin
                    xfer_we[xfer_n]   = mem_we;
                    xfer_addr[xfer_n] = mem_addr;
                    xfer_data[xfer_n] = mem_wdata;
                end
                xfer_n++;
                if (mem_we) bmem[mem_addr[31:4]] = mem_wdata;
                else        mem_rdata = back_line(mem_addr[31:4]);
                mem_ack = 1'b1;
            end
        end
    end

    task automatic access(bit we, bit [31:0] addr, bit [31:0] wdata, string req);
        bit [7:0]  idx  = addr[11:4];
        bit [19:0] tag  = addr[31:12];
        bit        hit  = m_valid[idx] && m_tag[idx] == tag;
        bit        wb   = !hit && m_valid[idx] && m_dirty[idx];
        int        exp_n = hit ? 0 : (wb ? 2 : 1);
        bit [31:0] exp_rd = ref_rd(addr[31:2]);
        bit [31:0] vict_addr = {m_tag[idx], idx, 4'h0};
        bit [127:0] vict_line = ref_line({m_tag[idx], idx});
        int        cyc = 0;
        bit        seen = 0;
        xfer_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        while (!seen && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (mem_req && cpu_ready)
                check(0, "R9", "ready during transfer", 1, 0);
            if (cpu_ready) seen = 1;
        end
        check(seen, req, "ready seen", seen, 1);
        if (hit && !we) check(cyc == 1, "R3", "hit latency", cyc, 1);
        if (!we) check(cpu_rdata == exp_rd, req, "load data", cpu_rdata, exp_rd);
        cpu_req = 1'b0;
        @(negedge clk);
        check(!cpu_ready, "R9", "single ready pulse", cpu_ready, 0);
        check(xfer_n == exp_n, req, "transfer count", xfer_n, exp_n);
        if (xfer_n == exp_n && wb) begin
            check(xfer_we[0] && xfer_addr[0] == vict_addr, "R6", "write-back address",
                  {xfer_we[0], xfer_addr[0]}, {1'b1, vict_addr});
            check(xfer_data[0] == vict_line, "R6", "write-back line", xfer_data[0], vict_line);
        end
        if (xfer_n == exp_n && exp_n > 0) begin
            check(!xfer_we[exp_n-1] && xfer_addr[exp_n-1] == {addr[31:4], 4'h0}, "R7",
                  "refill address", {xfer_we[exp_n-1], xfer_addr[exp_n-1]}, {1'b0, addr[31:4], 4'h0});
        end
        m_valid[idx] = 1'b1;
        m_tag[idx]   = tag;
        if (!hit) m_dirty[idx] = 1'b0;
        if (we) begin
            m_dirty[idx] = 1'b1;
            refw[addr[31:2]] = wdata;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit [7:0] idx_pool [4] = '{8'h00, 8'h01, 8'h02, 8'hFF};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0;
        end
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        xfer_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!cpu_ready && !mem_req, "R10", "idle after reset", {cpu_ready, mem_req}, 0);

        access(0, 32'h0000_0000, 0, "R10");            // first access misses
        access(0, 32'h0000_0004, 0, "R3");             // load hit
        access(0, 32'h0000_0007, 0, "R1");             // byte bits ignored
        access(1, 32'h0000_0008, 32'hDEAD_BEEF, "R4"); // store hit, no transfer
        access(0, 32'h0000_0009, 0, "R4");             // reads merged word
        access(0, 32'h0000_1000, 0, "R6");             // dirty victim written back
        access(0, 32'h0000_0008, 0, "R8");             // clean victim, refill only
        access(1, 32'h0000_2014, 32'h1234_5678, "R5"); // store miss allocates
        access(0, 32'h0000_3010, 0, "R5");             // evicts merged block
        access(0, 32'h0000_2014, 0, "R2");             // same index, tag differs
        access(1, 32'h0000_0FFC, 32'hA5A5_5A5A, "R7"); // index 255, invalid victim
        access(0, 32'h0000_0FF0, 0, "R1");             // word 0 of line 255

        for (int n = 0; n < 600; n++) begin
            bit [31:0] a;
            a = {18'($urandom_range(0, 3)), idx_pool[$urandom_range(0, 3)],
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            a = {a[31:12] & 20'h3, a[11:0]};
            access($urandom_range(0, 1) == 1, a, $urandom, "R2");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule